// File: doc/BRIEF.md
# Key-Unlocked Register Write Guard

This block guards one 8-bit control register behind a three-byte unlock key. It watches a byte-oriented register-write transaction: a start condition, one address byte, then any number of data bytes, closed by a stop or cut short by a new start. When the address byte selects the protected location (2Dh by default), the next three data bytes must be 43h, 4Dh and 53h in that order. Only then is the byte after them taken as the new register value.

A wrong key byte locks the transaction, and every later byte is dropped until the next stop or start. Reads go through a separate combinational read port and need no key.

The block also keeps the auto-increment pointer used by burst writes to ordinary registers. A burst that starts below the protected address and runs across it has its byte at that address thrown away, and the pointer moves on to 2Eh. Only three bits of the register exist: bit 0 enables the watchdog pin, bit 1 enables the nonvolatile store, and bit 2 sets the read-only lock. All other bits are reserved.

The sequencer has six named states:
- ST_IDLE: outside a transaction.
- ST_ADDR: waiting for the address byte.
- ST_KEY: matching key bytes, using an index.
- ST_VALUE: waiting for the value byte.
- ST_BURST: ordinary auto-increment writes.
- ST_LOCKED: key failed.

Its transitions are:
- A start from any state goes to ST_ADDR. A stop from any state goes to ST_IDLE. A start takes precedence over a stop.
- ST_ADDR goes to ST_KEY on the protected address and to ST_BURST on any other address.
- ST_KEY stays in ST_KEY on a matching byte that is not the last key byte. It goes to ST_VALUE on the last matching key byte and to ST_LOCKED on any mismatch.
- ST_VALUE goes to ST_BURST on the value byte.
- ST_BURST and ST_LOCKED hold until a start or a stop.

Top module: `key_guard_top`

## Requirements
- R1: After reset the protected register reads 00h, the pointer is 00h and the block is outside any transaction.
- R2: After start, address 2Dh and the data bytes 43h, 4Dh, 53h, the next data byte is stored into the register on the clock edge that accepts it. Only bits 2:0 are stored (bit 0 watchdog pin enable, bit 1 store enable, bit 2 read-only lock).
- R3: The read port returns the register whenever the read address equals 2Dh, and 00h for any other read address, with no key needed.
- R4: In a burst that began at a lower address, a data byte that arrives while the pointer is 2Dh leaves the register unchanged and moves the pointer to 2Eh.
- R5: Register bits 7:3 always read 0, whatever value is written.
- R6: A key byte that differs from the expected one aborts the unlock. Every later data byte of that transaction, including a correct key sequence, changes neither the register nor the pointer.
- R7: A stop that arrives before the value byte leaves the register unchanged. Data bytes outside a transaction are ignored.
- R8: After the value byte the pointer reads 2Eh, and later data bytes in the same transaction increment it by one each.
- R9: A new start, with or without a stop before it, clears a locked state so that a fresh key sequence can write the register.
- R10: The address byte loads the pointer, and key bytes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | One-cycle pulse: start condition |
| txn_stop | input | 1 | One-cycle pulse: stop condition |
| addr_vld | input | 1 | Address byte valid |
| addr_byte | input | AW | Register address byte |
| data_vld | input | 1 | Data byte valid |
| data_byte | input | 8 | Data byte |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read data (combinational) |
| prot_q | output | 8 | Protected register contents |
| ptr_q | output | AW | Auto-increment pointer |

## Verification
Each state leaves a trace at the ports. An error in the sequencer state or in the key index appears either as a register update that the key did not earn or as a correct key that fails to update the register. Either effect is visible on prot_q one edge after the value byte. A wrong pointer step appears on ptr_q on the edge right after the byte that moved it, as an advance during key bytes, a failure to hold while locked, or a miss of the 2Eh skip. A lost lock appears as a register change at the value position of a transaction whose key was rejected.

// File: rtl/key_guard_pkg.sv
package key_guard_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_KEY    = 3'd2,
        ST_VALUE  = 3'd3,
        ST_BURST  = 3'd4,
        ST_LOCKED = 3'd5
    } guard_state_e;
endpackage

// File: rtl/guard_key_sel.sv
module guard_key_sel #(
    parameter int                  KEY_LEN = 3,
    parameter logic [KEY_LEN*8-1:0] KEY    = 24'h434D53,
    localparam int                 IW      = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1
) (
    input  logic [IW-1:0] key_idx,
    input  logic [7:0]    data_byte,
    output logic          key_match,
    output logic          key_last
);
    logic [7:0] key_arr [KEY_LEN];
    logic [7:0] expect_byte;

    for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
        assign key_arr[g] = KEY[(KEY_LEN-1-g)*8 +: 8];
    end

    always_comb begin
        expect_byte = 8'h00;
        for (int i = 0; i < KEY_LEN; i++) begin
            if (key_idx == IW'(i)) expect_byte = key_arr[i];
        end
    end

    assign key_match = (data_byte == expect_byte);
    assign key_last  = (key_idx == IW'(KEY_LEN-1));
endmodule

// File: rtl/guard_fsm.sv
module guard_fsm
    import key_guard_pkg::*;
#(
    parameter int              AW        = 8,
    parameter logic [AW-1:0]   PROT_ADDR = 8'h2D,
    parameter int              KEY_LEN   = 3,
    localparam int             IW        = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          txn_start,
    input  logic          txn_stop,
    input  logic          addr_vld,
    input  logic [AW-1:0] addr_byte,
    input  logic          data_vld,
    input  logic          key_match,
    input  logic          key_last,
    output guard_state_e  state,
    output logic [IW-1:0] key_idx,
    output logic          ptr_load,
    output logic          burst_step,
    output logic          value_we
);
    guard_state_e  state_n;
    logic [IW-1:0] idx_n;
    logic          ctrl;

    assign ctrl = txn_start | txn_stop;

    always_comb begin
        state_n = state;
        idx_n   = key_idx;
        if (txn_start) begin
            state_n = ST_ADDR;
            idx_n   = '0;
        end else if (txn_stop) begin
            state_n = ST_IDLE;
            idx_n   = '0;
        end else begin
            unique case (state)
                ST_IDLE:   state_n = ST_IDLE;
                ST_ADDR: begin
                    if (addr_vld) begin
                        state_n = (addr_byte == PROT_ADDR) ? ST_KEY : ST_BURST;
                    end
                end
                ST_KEY: begin
                    if (data_vld) begin
                        if (!key_match)    state_n = ST_LOCKED;
                        else if (key_last) state_n = ST_VALUE;
                        else               idx_n   = key_idx + 1'b1;
                    end
                end
                ST_VALUE:  if (data_vld) state_n = ST_BURST;
                ST_BURST:  state_n = ST_BURST;
                ST_LOCKED: state_n = ST_LOCKED;
                default:   state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            key_idx <= '0;
        end else begin
            state   <= state_n;
            key_idx <= idx_n;
        end
    end

    always_comb begin
        ptr_load   = 1'b0;
        burst_step = 1'b0;
        value_we   = 1'b0;
        if (!ctrl) begin
            unique case (state)
                ST_ADDR:  ptr_load   = addr_vld;
                ST_BURST: burst_step = data_vld;
                ST_VALUE: value_we   = data_vld;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/guard_regs.sv
module guard_regs #(
    parameter int            AW        = 8,
    parameter logic [AW-1:0] PROT_ADDR = 8'h2D,
    parameter logic [7:0]    BIT_MASK  = 8'h07
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_load,
    input  logic          burst_step,
    input  logic          value_we,
    input  logic [AW-1:0] addr_byte,
    input  logic [7:0]    data_byte,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [7:0]    prot_q,
    output logic [AW-1:0] ptr_q
);
    localparam logic [AW-1:0] AFTER_PROT = PROT_ADDR + AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            prot_q <= 8'h00;
        end else begin
            if (ptr_load) begin
                ptr_q <= addr_byte;
            end else if (burst_step) begin
                ptr_q <= ptr_q + AW'(1);
            end else if (value_we) begin
                ptr_q  <= AFTER_PROT;
                prot_q <= data_byte & BIT_MASK;
            end
        end
    end

    assign rd_data = (rd_addr == PROT_ADDR) ? prot_q : 8'h00;
endmodule

// File: rtl/key_guard_top.sv
module key_guard_top
    import key_guard_pkg::*;
#(
    parameter int                  AW        = 8,
    parameter logic [AW-1:0]       PROT_ADDR = 8'h2D,
    parameter int                  KEY_LEN   = 3,
    parameter logic [KEY_LEN*8-1:0] KEY      = 24'h434D53,
    parameter logic [7:0]          BIT_MASK  = 8'h07
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          txn_start,
    input  logic          txn_stop,
    input  logic          addr_vld,
    input  logic [AW-1:0] addr_byte,
    input  logic          data_vld,
    input  logic [7:0]    data_byte,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [7:0]    prot_q,
    output logic [AW-1:0] ptr_q
);
    localparam int IW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;

    guard_state_e  st;
    logic [IW-1:0] key_idx;
    logic          key_match, key_last;
    logic          ptr_load, burst_step, value_we;

    guard_key_sel #(.KEY_LEN(KEY_LEN), .KEY(KEY)) u_key (
        .key_idx   (key_idx),
        .data_byte (data_byte),
        .key_match (key_match),
        .key_last  (key_last)
    );

    guard_fsm #(.AW(AW), .PROT_ADDR(PROT_ADDR), .KEY_LEN(KEY_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_start  (txn_start),
        .txn_stop   (txn_stop),
        .addr_vld   (addr_vld),
        .addr_byte  (addr_byte),
        .data_vld   (data_vld),
        .key_match  (key_match),
        .key_last   (key_last),
        .state      (st),
        .key_idx    (key_idx),
        .ptr_load   (ptr_load),
        .burst_step (burst_step),
        .value_we   (value_we)
    );

    guard_regs #(.AW(AW), .PROT_ADDR(PROT_ADDR), .BIT_MASK(BIT_MASK)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_load   (ptr_load),
        .burst_step (burst_step),
        .value_we   (value_we),
        .addr_byte  (addr_byte),
        .data_byte  (data_byte),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .prot_q     (prot_q),
        .ptr_q      (ptr_q)
    );
endmodule

// File: rtl/key_guard_chk.sv
module key_guard_chk
    import key_guard_pkg::*;
#(
    parameter int            AW        = 8,
    parameter logic [AW-1:0] PROT_ADDR = 8'h2D,
    parameter logic [7:0]    BIT_MASK  = 8'h07
) (
    input logic          clk,
    input logic          rst_n,
    input logic          txn_start,
    input logic          txn_stop,
    input logic          data_vld,
    input guard_state_e  st,
    input logic [7:0]    prot_q,
    input logic [AW-1:0] ptr_q
);
    logic quiet;
    assign quiet = !txn_start && !txn_stop;

    p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_q & ~BIT_MASK) == 8'h00);

    p_hold_unless_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(st == ST_VALUE && data_vld && quiet) |=> $stable(prot_q));

    p_burst_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BURST && data_vld && quiet && ptr_q == PROT_ADDR)
        |=> (ptr_q == PROT_ADDR + AW'(1)) && $stable(prot_q));

    p_locked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOCKED && quiet) |=> st == ST_LOCKED && $stable(ptr_q) && $stable(prot_q));

    p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_stop && !txn_start) |=> st == ST_IDLE);

    p_key_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_KEY && quiet) |=> $stable(ptr_q));
endmodule

bind key_guard_top key_guard_chk #(.AW(AW), .PROT_ADDR(PROT_ADDR), .BIT_MASK(BIT_MASK)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .txn_start (txn_start),
    .txn_stop  (txn_stop),
    .data_vld  (data_vld),
    .st        (st),
    .prot_q    (prot_q),
    .ptr_q     (ptr_q)
);

// File: tb/key_guard_top_tb_top.sv
module key_guard_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_start = 1'b0, txn_stop = 1'b0;
    logic       addr_vld = 1'b0, data_vld = 1'b0;
    logic [7:0] addr_byte = 8'h00, data_byte = 8'h00, rd_addr = 8'h00;
    logic [7:0] rd_data, prot_q, ptr_q;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    key_guard_top dut_i (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_stop(txn_stop),
        .addr_vld(addr_vld), .addr_byte(addr_byte), .data_vld(data_vld),
        .data_byte(data_byte), .rd_addr(rd_addr), .rd_data(rd_data),
        .prot_q(prot_q), .ptr_q(ptr_q)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_start();
        txn_start = 1'b1; @(negedge clk); txn_start = 1'b0;
    endtask
    task automatic do_stop();
        txn_stop = 1'b1; @(negedge clk); txn_stop = 1'b0;
    endtask
    task automatic do_addr(logic [7:0] a);
        addr_vld = 1'b1; addr_byte = a; @(negedge clk); addr_vld = 1'b0;
    endtask
    task automatic do_data(logic [7:0] d);
        data_vld = 1'b1; data_byte = d; @(negedge clk); data_vld = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 prot", prot_q, 8'h00);
        check("R1 ptr", ptr_q, 8'h00);
        rd_addr = 8'h2D; #1;
        check("R1 read", rd_data, 8'h00);
    endtask

    task automatic t_unlock_write();
        do_start(); do_addr(8'h2D);
        check("R10 addr loads ptr", ptr_q, 8'h2D);
        do_data(8'h43);
        check("R10 key keeps ptr", ptr_q, 8'h2D);
        do_data(8'h4D); do_data(8'h53);
        check("R2 not yet written", prot_q, 8'h00);
        do_data(8'hFF);
        check("R2 value masked", prot_q, 8'h07);
        check("R5 reserved zero", prot_q & 8'hF8, 8'h00);
        check("R8 ptr after value", ptr_q, 8'h2E);
        do_data(8'hAA);
        check("R8 ptr increments", ptr_q, 8'h2F);
        check("R8 prot untouched", prot_q, 8'h07);
        do_stop();
        rd_addr = 8'h2D; #1;
        check("R3 read prot", rd_data, 8'h07);
        rd_addr = 8'h2C; #1;
        check("R3 read other", rd_data, 8'h00);
    endtask

    task automatic t_burst_skip();
        do_start(); do_addr(8'h2B);
        do_data(8'h11); do_data(8'h22);
        check("R4 ptr at prot", ptr_q, 8'h2D);
        do_data(8'h00);
        check("R4 byte discarded", prot_q, 8'h07);
        check("R4 ptr skipped", ptr_q, 8'h2E);
        do_data(8'h44);
        check("R4 ptr continues", ptr_q, 8'h2F);
        do_stop();
    endtask

    task automatic t_wrong_key();
        do_start(); do_addr(8'h2D);
        do_data(8'h43); do_data(8'h4E);
        do_data(8'h43); do_data(8'h4D); do_data(8'h53); do_data(8'h02);
        check("R6 prot held", prot_q, 8'h07);
        check("R6 ptr held", ptr_q, 8'h2D);
        do_stop();
        do_start(); do_addr(8'h2D); do_data(8'h00); do_data(8'h01);
        check("R6 first byte wrong", prot_q, 8'h07);
        do_stop();
    endtask

    task automatic t_early_stop();
        do_start(); do_addr(8'h2D);
        do_data(8'h43); do_data(8'h4D); do_data(8'h53);
        do_stop();
        do_data(8'h00);
        check("R7 stop before value", prot_q, 8'h07);
        check("R7 idle byte ignored", ptr_q, 8'h2D);
    endtask

    task automatic t_restart();
        do_start(); do_addr(8'h2D); do_data(8'h99);
        do_start(); do_addr(8'h2D);
        do_data(8'h43); do_data(8'h4D); do_data(8'h53); do_data(8'h02);
        check("R9 restart unlocks", prot_q, 8'h02);
        do_start(); do_addr(8'h2D);
        do_data(8'h43); do_data(8'h4D); do_data(8'h53); do_data(8'h00);
        check("R2 clear all bits", prot_q, 8'h00);
        do_stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unlock_write();
        t_burst_skip();
        t_wrong_key();
        t_early_stop();
        t_restart();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule